// File: doc/BRIEF.md
# 2B+D TDM Bus Slot Controller

This block runs a serial time-division multiplexed bus that carries the two bearer channels and the signalling channel of two line interfaces, called A and B. A frame holds a parameterised number of 8-bit slots, 32 by default. Slots 0 to 2 carry A's B1, B2 and D channels, and slots 4 to 6 carry B's B1, B2 and D channels. The block divides the system clock down to a bit clock. It shifts transmit data out MSB first on the rising bit-clock edge and samples the serial input on the falling edge. It also produces a frame strobe that a register bank can aim at one slot or at a whole channel group.

Transmit bytes come from parallel ports and are frozen at the start of each frame. Received bytes land in per-channel output registers, each with a one-cycle valid pulse. The serial output has an enable that the pad uses to tri-state the pin. That enable is asserted only during the live bits of enabled reserved slots. The D channel uses only the first two bits of its octet. The bus stays fully quiet until it is enabled with an active-low enable and at least one slot enable bit is set.

Top module: `tdm_slot_ctrl`

## Requirements
- R1: After reset, and in the cycle after any edge that sees `bus_en_n` = 1 or `slot_en` = 0, the outputs `tdm_clk`, `tdm_fs`, `tdm_do_oe`, `tdm_do` and `rx_valid` are all 0.
- R2: Once running, `tdm_clk` is high for CLK_HALF system cycles and then low for CLK_HALF cycles. Its first high phase begins in the cycle after enabling and carries slot 0, bit 0. A frame lasts NUM_SLOTS*8 bit periods and then repeats from slot 0.
- R3: Channel index k is bit k of `slot_en` and bit k of `rx_valid`. The mapping is 0 = A-B1 in slot 0, 1 = A-B2 in slot 1, 2 = A-D in slot 2, 3 = B-B1 in slot 4, 4 = B-B2 in slot 5 and 5 = B-D in slot 6. Slot 3 and slots 7 and up are never driven.
- R4: In an enabled B slot, `tdm_do_oe` is 1 for all 8 bit periods. `tdm_do` carries the latched byte MSB first, and each bit holds for one full bit period starting at the rising edge of `tdm_clk`.
- R5: In an enabled D slot, `tdm_do_oe` is 1 only for bit periods 0 and 1, which carry d[1] and then d[0]. It is 0 for the remaining six bit periods.
- R6: `tdm_do_oe` is 0 in slots whose enable bit is clear. `tdm_do` is 0 whenever `tdm_do_oe` is 0.
- R7: `tdm_di` is sampled on the falling edge of `tdm_clk`. Once the last live bit of an enabled slot has been sampled, the channel's rx port holds the bits first-received-in-MSB. For a D slot, the two bits go in [1:0]. The matching `rx_valid` bit is high for exactly one system cycle, at the start of the low phase of that bit period.
- R8: Serial input in unused or disabled slots is ignored. No valid pulse occurs and every rx port keeps its value.
- R9: With `fs_inv` = 0, `tdm_fs` is high for every bit period of the selected envelope and low otherwise. `fs_sel` values 0 to 5 select the slot of channel `fs_sel`, 6 selects slots 0 to 2, and 7 selects slots 4 to 6.
- R10: With `fs_inv` = 1 and the bus running, `tdm_fs` is the inverse of the R9 envelope.
- R11: The transmit ports are latched in the cycle that starts each frame. Changing them during a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_n | input | 1 | Bus enable, 0 = enabled |
| slot_en | input | 6 | Per-channel slot enable (index per R3) |
| fs_sel | input | 3 | Frame strobe envelope select |
| fs_inv | input | 1 | Frame strobe polarity invert |
| tx_a_b1 | input | 8 | Interface A B1 transmit byte |
| tx_a_b2 | input | 8 | Interface A B2 transmit byte |
| tx_a_d | input | 2 | Interface A D transmit bits |
| tx_b_b1 | input | 8 | Interface B B1 transmit byte |
| tx_b_b2 | input | 8 | Interface B B2 transmit byte |
| tx_b_d | input | 2 | Interface B D transmit bits |
| rx_a_b1 | output | 8 | Interface A B1 receive byte |
| rx_a_b2 | output | 8 | Interface A B2 receive byte |
| rx_a_d | output | 2 | Interface A D receive bits |
| rx_b_b1 | output | 8 | Interface B B1 receive byte |
| rx_b_b2 | output | 8 | Interface B B2 receive byte |
| rx_b_d | output | 2 | Interface B D receive bits |
| rx_valid | output | 6 | One-cycle capture pulse per channel |
| tdm_clk | output | 1 | Bus bit clock |
| tdm_fs | output | 1 | Frame strobe |
| tdm_do | output | 1 | Serial data out |
| tdm_do_oe | output | 1 | Serial output drive enable (0 = pin tri-stated) |
| tdm_di | input | 1 | Serial data in |

## Verification
The bench builds the block with CLK_HALF = 2 and NUM_SLOTS = 8, so a bit period is four system cycles and a frame is 256 cycles. At that size, every one of the 64 slot-enable patterns can be run for whole frames. Each run pairs its pattern with a different strobe select and polarity, and every output is compared cycle by cycle against positions computed arithmetically. The short frame still contains both unused gaps and both D slots. It also lets the bench change the transmit ports mid-frame and check that the second group ignores the change, and compare the receive registers after every slot, enabled or not.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  localparam int NUM_CH = 6;

  typedef enum logic [2:0] {
    CH_A_B1 = 3'd0,
    CH_A_B2 = 3'd1,
    CH_A_D  = 3'd2,
    CH_B_B1 = 3'd3,
    CH_B_B2 = 3'd4,
    CH_B_D  = 3'd5
  } chan_e;

  typedef struct packed {
    logic  hit;
    chan_e ch;
  } slot_map_t;

  localparam logic [2:0] FS_GROUP_A = 3'd6;
  localparam logic [2:0] FS_GROUP_B = 3'd7;

  // Fixed placement of the six reserved slots within a frame.
  function automatic slot_map_t map_slot(input int slot);
    slot_map_t m;
    m.hit = 1'b1;
    m.ch  = CH_A_B1;
    case (slot)
      0:       m.ch = CH_A_B1;
      1:       m.ch = CH_A_B2;
      2:       m.ch = CH_A_D;
      4:       m.ch = CH_B_B1;
      5:       m.ch = CH_B_B2;
      6:       m.ch = CH_B_D;
      default: m.hit = 1'b0;
    endcase
    return m;
  endfunction

  function automatic logic is_d(input chan_e ch);
    return (ch == CH_A_D) || (ch == CH_B_D);
  endfunction

  function automatic logic in_group_b(input chan_e ch);
    return ch >= CH_B_B1;
  endfunction

  // Index of the last bit of a slot that carries data.
  function automatic logic [2:0] last_live_bit(input chan_e ch);
    return is_d(ch) ? 3'd1 : 3'd7;
  endfunction

  function automatic logic bit_is_live(input chan_e ch, input logic [2:0] bit_idx);
    return !is_d(ch) || (bit_idx < 3'd2);
  endfunction

endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase #(
  parameter int CLK_HALF  = 12,
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              run,
  output logic              tdm_clk,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [2:0]        bit_idx,
  output logic              smp_stb,
  output logic              frame_ld
);

  localparam int PER   = 2 * CLK_HALF;
  localparam int DIV_W = (PER > 1) ? $clog2(PER) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(PER - 1);
  localparam logic [DIV_W-1:0]  DIV_SMP   = DIV_W'(CLK_HALF - 1);
  localparam logic [DIV_W-1:0]  DIV_HIGH  = DIV_W'(CLK_HALF);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic              run_q, run_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [2:0]        bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              div_end, bit_end, slot_end, adv_bit;

  assign div_end  = (div_q == DIV_LAST);
  assign bit_end  = (bit_q == 3'd7);
  assign slot_end = (slot_q == SLOT_LAST);
  assign adv_bit  = run_q && go && div_end;

  always_comb begin
    run_d  = go;
    div_d  = div_q;
    bit_d  = bit_q;
    slot_d = slot_q;
    if (!go || !run_q) begin
      div_d  = '0;
      bit_d  = '0;
      slot_d = '0;
    end else begin
      div_d = div_end ? '0 : div_q + DIV_W'(1);
      if (adv_bit) begin
        bit_d = bit_q + 3'd1;
        if (bit_end) begin
          slot_d = slot_end ? '0 : slot_q + SLOT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      run_q  <= run_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end

  assign run      = run_q;
  assign tdm_clk  = run_q && (div_q < DIV_HIGH);
  assign slot_idx = slot_q;
  assign bit_idx  = bit_q;
  assign smp_stb  = run_q && go && (div_q == DIV_SMP);
  assign frame_ld = go && (!run_q || (div_end && bit_end && slot_end));

  // R2: the last bit period of a frame is followed by slot 0, bit 0
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && go && div_end && bit_end && slot_end) |=>
      (slot_q == '0 && bit_q == 3'd0 && tdm_clk));

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ld,
  input  logic              run,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [2:0]        bit_idx,
  input  logic [NUM_CH-1:0] slot_en,
  input  logic [7:0]        tx_a_b1,
  input  logic [7:0]        tx_a_b2,
  input  logic [1:0]        tx_a_d,
  input  logic [7:0]        tx_b_b1,
  input  logic [7:0]        tx_b_b2,
  input  logic [1:0]        tx_b_d,
  output logic              tdm_do,
  output logic              tdm_do_oe
);

  logic [NUM_CH-1:0][7:0] load_v;
  logic [NUM_CH-1:0][7:0] hold_q, hold_d;
  slot_map_t              m;
  logic                   drive;

  // D bits are kept left-aligned so every slot shifts from bit 7 down.
  assign load_v = {{tx_b_d, 6'b0}, tx_b_b2, tx_b_b1,
                   {tx_a_d, 6'b0}, tx_a_b2, tx_a_b1};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
    always_comb begin
      hold_d[c] = hold_q[c];
      if (frame_ld) begin
        hold_d[c] = load_v[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[c] <= '0;
      end else begin
        hold_q[c] <= hold_d[c];
      end
    end
  end

  always_comb begin
    m     = map_slot(int'(slot_idx));
    drive = run && m.hit && slot_en[m.ch] && bit_is_live(m.ch, bit_idx);
  end

  assign tdm_do_oe = drive;
  assign tdm_do    = drive && hold_q[m.ch][3'd7 - bit_idx];

  // R11: the held transmit bytes only change at a frame start
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ld |=> $stable(hold_q));

  // R5: a D slot never drives past its two live bits
  a_r5_d_window: assert property (@(posedge clk) disable iff (!rst_n)
    (tdm_do_oe && (slot_idx == SLOT_W'(2) || slot_idx == SLOT_W'(6))) |-> (bit_idx < 3'd2));

  // R6: no drive unless the bus runs and the slot is reserved and enabled
  a_r6_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tdm_do_oe |-> (run && slot_idx != SLOT_W'(3) && slot_idx < SLOT_W'(7)));

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_stb,
  input  logic [SLOT_W-1:0]      slot_idx,
  input  logic [2:0]             bit_idx,
  input  logic [NUM_CH-1:0]      slot_en,
  input  logic                   tdm_di,
  output logic [NUM_CH-1:0][7:0] rx_data,
  output logic [NUM_CH-1:0]      rx_valid
);

  slot_map_t              m;
  logic                   cap, done;
  logic [6:0]             sh_q, sh_d;
  logic [NUM_CH-1:0][7:0] rx_q, rx_d;
  logic [NUM_CH-1:0]      vld_q, vld_d;

  always_comb begin
    m    = map_slot(int'(slot_idx));
    cap  = smp_stb && m.hit && slot_en[m.ch] && bit_is_live(m.ch, bit_idx);
    done = cap && (bit_idx == last_live_bit(m.ch));
    sh_d = sh_q;
    if (cap) begin
      sh_d = {sh_q[5:0], tdm_di};
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
    localparam chan_e CH = chan_e'(c);
    logic hit_c;

    always_comb begin
      hit_c    = done && (m.ch == CH);
      vld_d[c] = hit_c;
      rx_d[c]  = rx_q[c];
      if (hit_c) begin
        rx_d[c] = is_d(CH) ? {6'b0, sh_q[0], tdm_di} : {sh_q, tdm_di};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_q[c]  <= '0;
        vld_q[c] <= 1'b0;
      end else begin
        rx_q[c]  <= rx_d[c];
        vld_q[c] <= vld_d[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rx_data  = rx_q;
  assign rx_valid = vld_q;

  // R7: at most one channel completes at a time
  a_r7_valid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_valid));

  // R7: a valid pulse lasts a single cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |=> !(|rx_valid));

  // R8: a channel's register moves only together with its valid pulse
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid == '0) |-> $stable(rx_data));

endmodule

// File: rtl/tdm_strobe.sv
module tdm_strobe
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              run,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [2:0]        fs_sel,
  input  logic              fs_inv,
  output logic              tdm_fs
);

  slot_map_t m;
  logic      env;

  always_comb begin
    m = map_slot(int'(slot_idx));
    case (fs_sel)
      FS_GROUP_A: env = m.hit && !in_group_b(m.ch);
      FS_GROUP_B: env = m.hit && in_group_b(m.ch);
      default:    env = m.hit && (m.ch == chan_e'(fs_sel));
    endcase
    tdm_fs = run && (env ^ fs_inv);
  end

endmodule

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_pkg::*;
#(
  parameter int CLK_HALF  = 12,
  parameter int NUM_SLOTS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en_n,
  input  logic [5:0] slot_en,
  input  logic [2:0] fs_sel,
  input  logic       fs_inv,
  input  logic [7:0] tx_a_b1,
  input  logic [7:0] tx_a_b2,
  input  logic [1:0] tx_a_d,
  input  logic [7:0] tx_b_b1,
  input  logic [7:0] tx_b_b2,
  input  logic [1:0] tx_b_d,
  output logic [7:0] rx_a_b1,
  output logic [7:0] rx_a_b2,
  output logic [1:0] rx_a_d,
  output logic [7:0] rx_b_b1,
  output logic [7:0] rx_b_b2,
  output logic [1:0] rx_b_d,
  output logic [5:0] rx_valid,
  output logic       tdm_clk,
  output logic       tdm_fs,
  output logic       tdm_do,
  output logic       tdm_do_oe,
  input  logic       tdm_di
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic                   go, run, smp_stb, frame_ld;
  logic [SLOT_W-1:0]      slot_idx;
  logic [2:0]             bit_idx;
  logic [NUM_CH-1:0][7:0] rx_data;
  logic                   unused_rx_upper;

  assign go = !bus_en_n && (|slot_en);

  tdm_timebase #(
    .CLK_HALF (CLK_HALF),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .run     (run),
    .tdm_clk (tdm_clk),
    .slot_idx(slot_idx),
    .bit_idx (bit_idx),
    .smp_stb (smp_stb),
    .frame_ld(frame_ld)
  );

  tdm_tx #(.SLOT_W(SLOT_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_ld (frame_ld),
    .run      (run),
    .slot_idx (slot_idx),
    .bit_idx  (bit_idx),
    .slot_en  (slot_en),
    .tx_a_b1  (tx_a_b1),
    .tx_a_b2  (tx_a_b2),
    .tx_a_d   (tx_a_d),
    .tx_b_b1  (tx_b_b1),
    .tx_b_b2  (tx_b_b2),
    .tx_b_d   (tx_b_d),
    .tdm_do   (tdm_do),
    .tdm_do_oe(tdm_do_oe)
  );

  tdm_rx #(.SLOT_W(SLOT_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .slot_idx(slot_idx),
    .bit_idx (bit_idx),
    .slot_en (slot_en),
    .tdm_di  (tdm_di),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

  tdm_strobe #(.SLOT_W(SLOT_W)) u_strobe (
    .run     (run),
    .slot_idx(slot_idx),
    .fs_sel  (fs_sel),
    .fs_inv  (fs_inv),
    .tdm_fs  (tdm_fs)
  );

  assign rx_a_b1 = rx_data[CH_A_B1];
  assign rx_a_b2 = rx_data[CH_A_B2];
  assign rx_a_d  = rx_data[CH_A_D][1:0];
  assign rx_b_b1 = rx_data[CH_B_B1];
  assign rx_b_b2 = rx_data[CH_B_B2];
  assign rx_b_d  = rx_data[CH_B_D][1:0];
  assign unused_rx_upper = ^{rx_data[CH_A_D][7:2], rx_data[CH_B_D][7:2]};

  // R1: a disabled bus leaves every bus-facing output quiet
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_n || slot_en == 6'd0) |=>
      (!tdm_clk && !tdm_fs && !tdm_do_oe && !tdm_do && rx_valid == 6'd0));

  // R6: data out is low whenever the pin is released
  a_r6_do_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tdm_do_oe |-> !tdm_do);

endmodule

// File: tb/tb_tdm_slot_ctrl.sv
module tb_tdm_slot_ctrl;

  localparam int H   = 2;
  localparam int NS  = 8;
  localparam int PER = 2 * H;
  localparam int FB  = NS * 8;

  logic       clk;
  logic       rst_n;
  logic       bus_en_n;
  logic [5:0] slot_en;
  logic [2:0] fs_sel;
  logic       fs_inv;
  logic [7:0] tx_a_b1, tx_a_b2, tx_b_b1, tx_b_b2;
  logic [1:0] tx_a_d, tx_b_d;
  logic [7:0] rx_a_b1, rx_a_b2, rx_b_b1, rx_b_b2;
  logic [1:0] rx_a_d, rx_b_d;
  logic [5:0] rx_valid;
  logic       tdm_clk, tdm_fs, tdm_do, tdm_do_oe, tdm_di;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_rx [6];

  tdm_slot_ctrl #(.CLK_HALF(H), .NUM_SLOTS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .slot_en(slot_en),
    .fs_sel(fs_sel), .fs_inv(fs_inv),
    .tx_a_b1(tx_a_b1), .tx_a_b2(tx_a_b2), .tx_a_d(tx_a_d),
    .tx_b_b1(tx_b_b1), .tx_b_b2(tx_b_b2), .tx_b_d(tx_b_d),
    .rx_a_b1(rx_a_b1), .rx_a_b2(rx_a_b2), .rx_a_d(rx_a_d),
    .rx_b_b1(rx_b_b1), .rx_b_b2(rx_b_b2), .rx_b_d(rx_b_d),
    .rx_valid(rx_valid), .tdm_clk(tdm_clk), .tdm_fs(tdm_fs),
    .tdm_do(tdm_do), .tdm_do_oe(tdm_do_oe), .tdm_di(tdm_di)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input int cfg, input int fr, input int ch);
    return 8'((cfg * 53 + fr * 29 + ch * 71 + 17) ^ (cfg * 5));
  endfunction

  function automatic logic dibit(input int cfg, input int b);
    return ((b * 37 + cfg * 11 + (b / 5) * 3) % 7) < 3;
  endfunction

  function automatic int ch_of(input int slot);
    case (slot)
      0: return 0;
      1: return 1;
      2: return 2;
      4: return 3;
      5: return 4;
      6: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] rx_port(input int ch);
    case (ch)
      0: return rx_a_b1;
      1: return rx_a_b2;
      2: return {6'b0, rx_a_d};
      3: return rx_b_b1;
      4: return rx_b_b2;
      default: return {6'b0, rx_b_d};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic set_tx(input int cfg, input int fr);
    logic [7:0] pa, pb;
    tx_a_b1 = pat(cfg, fr, 0);
    tx_a_b2 = pat(cfg, fr, 1);
    pa      = pat(cfg, fr, 2);
    tx_a_d  = pa[1:0];
    tx_b_b1 = pat(cfg, fr, 3);
    tx_b_b2 = pat(cfg, fr, 4);
    pb      = pat(cfg, fr, 5);
    tx_b_d  = pb[1:0];
  endtask

  task automatic check_rx_regs(input string req);
    for (int c = 0; c < 6; c++) chk(req, rx_port(c), exp_rx[c]);
  endtask

  task automatic check_idle(input string req);
    chk(req, {tdm_clk, tdm_fs, tdm_do_oe, tdm_do, rx_valid}, 32'd0);
  endtask

  task automatic run_cfg(input int cfg, input logic [5:0] en, input logic [2:0] sel,
                         input logic inv, input int nfr);
    @(negedge clk);
    slot_en  = en;
    fs_sel   = sel;
    fs_inv   = inv;
    set_tx(cfg, 0);
    tdm_di   = dibit(cfg, 0);
    bus_en_n = 1'b0;
    for (int k = 0; k < nfr * FB * PER; k++) begin
      int b, dv, fr, fb, slot, bt, ch;
      logic running, live, isd, e_clk, e_oe, e_do, env, e_fs;
      logic [5:0] e_vld;
      logic [7:0] p, v;
      string lbl;
      @(negedge clk);
      b    = k / PER;
      dv   = k % PER;
      fr   = b / FB;
      fb   = b % FB;
      slot = fb / 8;
      bt   = fb % 8;
      ch   = ch_of(slot);
      running = (en != 6'd0);
      isd  = (ch == 2) || (ch == 5);
      live = (ch >= 0) && en[ch] && (!isd || bt < 2);
      e_clk = running && (dv < H);
      e_oe  = running && live;
      e_do  = 1'b0;
      if (e_oe) begin
        p    = pat(cfg, fr, ch);
        e_do = isd ? p[1 - bt] : p[7 - bt];
      end
      if (sel < 3'd6)       env = (ch == int'(sel));
      else if (sel == 3'd6) env = (slot < 3);
      else                  env = (slot >= 4) && (slot <= 6);
      e_fs  = running && (env ^ inv);
      e_vld = 6'd0;
      if (e_oe && dv == H && bt == (isd ? 1 : 7)) begin
        v = 8'd0;
        for (int i = 0; i < (isd ? 2 : 8); i++) v = {v[6:0], dibit(cfg, fr * FB + slot * 8 + i)};
        exp_rx[ch] = v;
        e_vld = 6'd1 << ch;
      end
      chk(running ? "R2" : "R1", tdm_clk, e_clk);
      if (!running)              lbl = "R1";
      else if (ch < 0)           lbl = "R3";
      else if (!en[ch])          lbl = "R6";
      else if (slot >= 4)        lbl = "R11";
      else if (isd)              lbl = "R5";
      else                       lbl = "R4";
      chk(lbl, {tdm_do_oe, tdm_do}, {e_oe, e_do});
      chk(inv ? "R10" : "R9", tdm_fs, e_fs);
      chk("R7", rx_valid, e_vld);
      check_rx_regs(e_vld != 6'd0 ? "R7" : "R8");
      if (slot == 3 && bt == 0 && dv == 0) set_tx(cfg, fr + 1);
      tdm_di = dibit(cfg, b + 1 - ((dv == PER - 1) ? 0 : 1));
    end
    bus_en_n = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check_idle("R1");
      check_rx_regs("R8");
      tdm_di = ~tdm_di;
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    bus_en_n = 1'b1;
    slot_en  = 6'd0;
    fs_sel   = 3'd0;
    fs_inv   = 1'b0;
    tdm_di   = 1'b0;
    set_tx(0, 0);
    for (int c = 0; c < 6; c++) exp_rx[c] = 8'd0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    check_rx_regs("R1");
    rst_n = 1'b1;
    // Slots enabled but bus enable held inactive: still quiet
    slot_en = 6'h3f;
    fs_inv  = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      check_idle("R1");
      tdm_di = ~tdm_di;
    end
    for (int c = 0; c < 64; c++) begin
      run_cfg(c, 6'(c), 3'((c * 3) % 8), 1'(((c >> 3) ^ (c >> 5)) & 1), (c % 4 == 0) ? 2 : 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule